// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is the command front end of a small serial EEPROM. An external controller selects it with an active-low chip select, sends 8-bit commands on the serial data input with the most significant bit first, and reads results back on a serial output that is driven only when the block has something to say. The block runs on its own faster system clock. It passes the serial clock, chip select and data input through synchronisers and acts on the edges it detects.

The byte array is held in on-chip registers. A write is never applied while bits are still arriving. Page data is first collected in a staging buffer. The buffer is committed in one system clock, but only when chip select returns high at a clean byte boundary. The commit starts a programming interval of fixed length, which is visible in the status byte. A write-enable latch must be armed before any array or status write, and every commit disarms it. Unknown commands silence the block until the next frame.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset `so_en` is low, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Command 0x06 sets the write-enable latch, seen as status bit 1. A page write or status write sent while the latch is clear changes nothing.
- R3: Every committed page write or status write clears the write-enable latch.
- R4: A page write is applied only when chip select rises after at least one complete data byte with no stray bits. A frame with a trailing partial byte, or with no data byte, writes nothing and leaves the latch set.
- R5: A commit holds status bit 0 high for WRITE_CYCLES system clocks. While bit 0 is high, every command other than status read (0x05) is ignored and the output stays disabled.
- R6: After an opcode that is not recognised, no further bits are taken in and `so_en` stays low until chip select falls again.
- R7: Status write is opcode 0x01 followed by exactly 8 data bits, 16 clocks in all. It stores data bits 7..2 into status bits 7..2. A frame of any other length is not applied.
- R8: Page write is opcode 0000_X010, then an address byte, then data bytes. The next data byte goes to the next address, and past the end of the 16-byte page the address wraps to the start of the same page. X is address bit 8 only when the 512-byte variant is selected; otherwise it must be 0.
- R9: Read is opcode 0000_X011 followed by an address byte. Data comes out most significant bit first, changing after each serial clock falling edge, and the address increments across page boundaries. Status read 0x05 repeats the live status byte for as long as the frame lasts.
- R10: Serial clock polarity and phase modes (0,0) and (1,1) are both accepted, with input data sampled on the serial clock rising edge.
- R11: Command 0x04 clears the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for the serial data out pad; low means high impedance |

## Verification
The programming timer can run out in the same system clock in which the status shifter reloads the live status byte for the next output byte. The bench provokes this overlap by starting one long status-read frame right after a commit and clocking bytes until bit 0 reads 0. It then requires that the first byte shows busy with the latch clear, that the first idle byte is exactly 0x00, and that the two bytes after it stay 0x00, so a torn or flickering reload is caught. The bench also runs a read during the busy interval to check that the output enable never rises.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [2:0] OP_WR_LOW = 3'b010;
  localparam logic [2:0] OP_RD_LOW = 3'b011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_SRDATA,
    ST_RDATA,
    ST_STAT,
    ST_BAD
  } ee_state_e;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];

  always_comb begin
    pipe_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        pipe_q[i] <= RST_VAL;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        pipe_q[i] <= pipe_d[i];
      end
    end
  end

  assign lvl = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_ee_busy_timer.sv
module spi_ee_busy_timer #(
  parameter int CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R5
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [ADDR_W-PAGE_W-1:0]     page,
  input  logic [(1<<PAGE_W)*8-1:0]     wdata,
  input  logic [(1<<PAGE_W)-1:0]       wmask,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [7:0]                   rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) begin
        mem_q[a] <= 8'hFF;
      end
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (wmask[i]) begin
          mem_q[{page, PAGE_W'(i)}] <= wdata[i*8 +: 8];
        end
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R4
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wmask != '0));

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter bit A8_MODE      = 1'b0,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 300,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_en
);

  localparam int ADDR_W = 8 + int'(A8_MODE);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int BUF_W  = PAGE_BYTES * 8;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_q;
  logic       rst_li;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_li = rst_q[1];

  // input synchronisers: bit0 sck, bit1 cs_n, bit2 si
  logic [2:0] pin_lvl;
  logic [1:0] edge_prev_q;
  logic       sck_rise, sck_fall, cs_rise, cs_fall, cs_hi, si_lvl;

  spi_ee_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_li),
    .din   ({si, cs_n, sck}),
    .lvl   (pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li) edge_prev_q <= 2'b10;
    else         edge_prev_q <= pin_lvl[1:0];
  end

  assign sck_rise = pin_lvl[0] & ~edge_prev_q[0];
  assign sck_fall = ~pin_lvl[0] & edge_prev_q[0];
  assign cs_rise  = pin_lvl[1] & ~edge_prev_q[1];
  assign cs_fall  = ~pin_lvl[1] & edge_prev_q[1];
  assign cs_hi    = pin_lvl[1];
  assign si_lvl   = pin_lvl[2];

  // state
  ee_state_e         state_q, state_d;
  logic [2:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              hi_q, hi_d;
  logic              rd_q, rd_d;
  logic [PAGE_W-1:0] off_q, off_d;
  logic              got_q, got_d;
  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic              wel_q, wel_d;
  logic [5:0]        st_q, st_d;
  logic              srfull_q, srfull_d;
  logic              srover_q, srover_d;
  logic [7:0]        out_q, out_d;
  logic [2:0]        obit_q, obit_d;
  logic              reload_q, reload_d;
  logic              so_q, so_d;
  logic              soen_q, soen_d;

  logic              commit_pg, commit_sr, buf_we, busy;
  logic [7:0]        sh_n, status_c, rd_data;
  logic              op_write, op_read;

  assign status_c = {st_q, wel_q, busy};
  assign sh_n     = {shreg_q[6:0], si_lvl};
  assign op_write = (sh_n[7:4] == 4'h0) && (sh_n[2:0] == OP_WR_LOW) && (A8_MODE || !sh_n[3]);
  assign op_read  = (sh_n[7:4] == 4'h0) && (sh_n[2:0] == OP_RD_LOW) && (A8_MODE || !sh_n[3]);

  always_comb begin
    state_d  = state_q;   bitcnt_d = bitcnt_q;  shreg_d  = shreg_q;
    addr_d   = addr_q;    hi_d     = hi_q;      rd_d     = rd_q;
    off_d    = off_q;     got_d    = got_q;     buf_d    = buf_q;
    mask_d   = mask_q;    wel_d    = wel_q;     st_d     = st_q;
    srfull_d = srfull_q;  srover_d = srover_q;  out_d    = out_q;
    obit_d   = obit_q;    reload_d = reload_q;  so_d     = so_q;
    soen_d   = soen_q;
    commit_pg = 1'b0;
    commit_sr = 1'b0;
    buf_we    = 1'b0;

    if (reload_q) begin
      out_d    = (state_q == ST_STAT) ? status_c : rd_data;
      reload_d = 1'b0;
    end

    if (cs_rise) begin
      if (state_q == ST_WDATA && bitcnt_q == 3'd0 && got_q && !busy) begin
        commit_pg = 1'b1;
        wel_d     = 1'b0;
      end
      if (state_q == ST_SRDATA && bitcnt_q == 3'd0 && srfull_q && !srover_q && !busy) begin
        commit_sr = 1'b1;
        st_d      = shreg_q[7:2];
        wel_d     = 1'b0;
      end
      state_d  = ST_IDLE;
      soen_d   = 1'b0;
      reload_d = 1'b0;
    end else if (cs_fall) begin
      state_d  = ST_CMD;
      bitcnt_d = 3'd0;
      soen_d   = 1'b0;
    end else if (!cs_hi) begin
      if (sck_rise) begin
        case (state_q)
          ST_CMD: begin
            shreg_d  = sh_n;
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              if (busy && sh_n != OP_RDSR) begin
                state_d = ST_IDLE;
              end else if (sh_n == OP_WREN) begin
                wel_d   = 1'b1;
                state_d = ST_IDLE;
              end else if (sh_n == OP_WRDI) begin
                wel_d   = 1'b0;
                state_d = ST_IDLE;
              end else if (sh_n == OP_RDSR) begin
                state_d  = ST_STAT;
                reload_d = 1'b1;
                obit_d   = 3'd0;
              end else if (sh_n == OP_WRSR) begin
                state_d  = wel_q ? ST_SRDATA : ST_IDLE;
                srfull_d = 1'b0;
                srover_d = 1'b0;
              end else if (op_write) begin
                state_d = wel_q ? ST_ADDR : ST_IDLE;
                rd_d    = 1'b0;
                hi_d    = sh_n[3];
              end else if (op_read) begin
                state_d = ST_ADDR;
                rd_d    = 1'b1;
                hi_d    = sh_n[3];
              end else begin
                state_d = ST_BAD;
              end
            end
          end
          ST_ADDR: begin
            shreg_d  = sh_n;
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              addr_d = ADDR_W'({hi_q, sh_n});
              if (rd_q) begin
                state_d  = ST_RDATA;
                reload_d = 1'b1;
                obit_d   = 3'd0;
              end else begin
                state_d = ST_WDATA;
                off_d   = sh_n[PAGE_W-1:0];
                got_d   = 1'b0;
                mask_d  = '0;
              end
            end
          end
          ST_WDATA: begin
            shreg_d  = sh_n;
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              buf_we = 1'b1;
              buf_d[int'(off_q)*8 +: 8] = sh_n;
              mask_d[off_q] = 1'b1;
              off_d = off_q + PAGE_W'(1);
              got_d = 1'b1;
            end
          end
          ST_SRDATA: begin
            shreg_d  = sh_n;
            bitcnt_d = bitcnt_q + 3'd1;
            if (srfull_q) srover_d = 1'b1;
            if (bitcnt_q == 3'd7) srfull_d = 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall && (state_q == ST_RDATA || state_q == ST_STAT)) begin
        so_d   = out_q[7];
        soen_d = 1'b1;
        out_d  = {out_q[6:0], 1'b0};
        obit_d = obit_q + 3'd1;
        if (obit_q == 3'd7) begin
          reload_d = 1'b1;
          if (state_q == ST_RDATA) addr_d = addr_q + ADDR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li) begin
      state_q  <= ST_IDLE;  bitcnt_q <= '0;  shreg_q  <= '0;
      addr_q   <= '0;       hi_q     <= 1'b0; rd_q    <= 1'b0;
      off_q    <= '0;       got_q    <= 1'b0; mask_q  <= '0;
      wel_q    <= 1'b0;     st_q     <= '0;   srfull_q <= 1'b0;
      srover_q <= 1'b0;     out_q    <= '0;   obit_q  <= '0;
      reload_q <= 1'b0;     so_q     <= 1'b0; soen_q  <= 1'b0;
    end else begin
      state_q  <= state_d;  bitcnt_q <= bitcnt_d; shreg_q  <= shreg_d;
      addr_q   <= addr_d;   hi_q     <= hi_d;     rd_q     <= rd_d;
      off_q    <= off_d;    got_q    <= got_d;    mask_q   <= mask_d;
      wel_q    <= wel_d;    st_q     <= st_d;     srfull_q <= srfull_d;
      srover_q <= srover_d; out_q    <= out_d;    obit_q   <= obit_d;
      reload_q <= reload_d; so_q     <= so_d;     soen_q   <= soen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li)     buf_q <= '0;
    else if (buf_we) buf_q <= buf_d;
  end

  spi_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_li),
    .commit  (commit_pg),
    .page    (addr_q[ADDR_W-1 -: PG_W]),
    .wdata   (buf_q),
    .wmask   (mask_q),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  spi_ee_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_li),
    .start (commit_pg | commit_sr),
    .busy  (busy)
  );

  assign so    = so_q;
  assign so_en = soen_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_li)
    (cs_hi && $past(cs_hi)) |-> !soen_q);

  // R2
  commit_wel_chk: assert property (@(posedge clk) disable iff (!rst_li)
    (commit_pg || commit_sr) |-> wel_q);

  // R3
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_li)
    (commit_pg || commit_sr) |=> !wel_q);

  // R5
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_li)
    (commit_pg || commit_sr) |-> !busy);

  // R6
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_li)
    (state_q == ST_BAD) |-> !soen_q);

  // R9
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_li)
    !$past(sck_fall) |-> $stable(so_q));

endmodule

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int BUSY_CYC   = 2000;
  localparam int WD_LIMIT   = 150000;

  localparam logic [15:0] VEC [6] = '{
    16'h00A5, 16'h015A, 16'h1FC3, 16'h800F, 16'hFE81, 16'hFF7E
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so, so_en;
  logic mode11 = 1'b0;
  logic oe_seen = 1'b0;
  logic [7:0] rdbuf [16];
  logic [7:0] wrbuf [16];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_slave #(.WRITE_CYCLES(BUSY_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_en(so_en)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      if (mode11) sck = 1'b0;
      si = tx[i];
      ticks(HALF);
      rx[i] = so;
      if (so_en) oe_seen = 1'b1;
      sck = 1'b1;
      ticks(HALF);
      if (!mode11) sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    bits(tx, 8, d);
  endtask

  task automatic fbegin();
    cs_n = 1'b0;
    ticks(HALF);
  endtask

  task automatic fend();
    ticks(HALF);
    cs_n = 1'b1;
    ticks(3*HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    fbegin(); send(op); fend();
  endtask

  task automatic rdsr(output logic [7:0] st);
    fbegin(); send(8'h05); bits(8'h00, 8, st); fend();
  endtask

  task automatic write_page(input logic [7:0] addr, input int n);
    fbegin(); send(8'h02); send(addr);
    for (int i = 0; i < n; i++) send(wrbuf[i]);
    fend();
  endtask

  task automatic read_seq(input logic [7:0] addr, input int n);
    logic [7:0] d;
    oe_seen = 1'b0;
    fbegin(); send(8'h03); send(addr);
    for (int i = 0; i < n; i++) begin
      bits(8'h00, 8, d);
      rdbuf[i] = d;
    end
    fend();
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    st = 8'h01;
    for (int k = 0; k < 60 && st[0]; k++) rdsr(st);
    chk("R5 ready", {7'd0, st[0]}, 8'h00);
  endtask

  initial begin
    logic [7:0] st, first;
    int n;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);

    // R1 reset state
    chk("R1 so_en", {7'd0, so_en}, 8'h00);
    rdsr(st);
    chk("R1 status", st, 8'h00);
    read_seq(8'h20, 1);
    chk("R1 array", rdbuf[0], 8'hFF);

    // R8 R3 table of single-byte writes
    for (int v = 0; v < 6; v++) begin
      cmd1(8'h06);
      wrbuf[0] = VEC[v][7:0];
      write_page(VEC[v][15:8], 1);
      wait_ready();
      rdsr(st);
      chk("R3 wel after commit", st, 8'h00);
      read_seq(VEC[v][15:8], 1);
      chk("R8 data", rdbuf[0], VEC[v][7:0]);
    end

    // R2 write without enable
    wrbuf[0] = 8'h5A;
    write_page(8'h30, 1);
    rdsr(st);
    chk("R2 no busy", st, 8'h00);
    read_seq(8'h30, 1);
    chk("R2 untouched", rdbuf[0], 8'hFF);
    cmd1(8'h06);
    rdsr(st);
    chk("R2 wel set", st, 8'h02);
    cmd1(8'h04);
    rdsr(st);
    chk("R11 wel clear", st, 8'h00);

    // R8 page wrap
    cmd1(8'h06);
    wrbuf[0] = 8'h11; wrbuf[1] = 8'h22; wrbuf[2] = 8'h33; wrbuf[3] = 8'h44;
    write_page(8'h4E, 4);
    wait_ready();
    read_seq(8'h40, 2);
    chk("R8 wrap 0x40", rdbuf[0], 8'h33);
    chk("R8 wrap 0x41", rdbuf[1], 8'h44);
    read_seq(8'h4E, 2);
    chk("R8 0x4E", rdbuf[0], 8'h11);
    chk("R8 0x4F", rdbuf[1], 8'h22);
    // R9 sequential read across page boundary
    read_seq(8'h4F, 2);
    chk("R9 seq 0x4F", rdbuf[0], 8'h22);
    chk("R9 seq 0x50", rdbuf[1], 8'hFF);

    // R4 partial byte and empty data
    cmd1(8'h06);
    fbegin(); send(8'h02); send(8'h60); send(8'h11); bits(8'hFF, 3, st); fend();
    read_seq(8'h60, 1);
    chk("R4 partial no write", rdbuf[0], 8'hFF);
    rdsr(st);
    chk("R4 wel kept", st, 8'h02);
    fbegin(); send(8'h02); send(8'h60); fend();
    rdsr(st);
    chk("R4 empty no busy", st, 8'h02);
    cmd1(8'h04);

    // R5 busy behaviour and coincident status reload
    cmd1(8'h06);
    wrbuf[0] = 8'hAB;
    write_page(8'h70, 1);
    rdsr(st);
    chk("R5 busy bit", st, 8'h01);
    read_seq(8'h70, 2);
    chk("R5 read ignored", {7'd0, oe_seen}, 8'h00);
    fbegin(); send(8'h05);
    bits(8'h00, 8, first);
    st = first;
    n = 0;
    while (st[0] && n < 40) begin
      bits(8'h00, 8, st);
      n++;
    end
    chk("R5 first busy", first, 8'h01);
    chk("R5 cleared", st, 8'h00);
    bits(8'h00, 8, st);
    chk("R9 repeat status", st, 8'h00);
    bits(8'h00, 8, st);
    chk("R9 repeat status 2", st, 8'h00);
    fend();
    read_seq(8'h70, 1);
    chk("R5 data kept", rdbuf[0], 8'hAB);

    // R6 invalid opcode
    oe_seen = 1'b0;
    fbegin(); send(8'hA5); send(8'h06); send(8'h05); send(8'h00); fend();
    chk("R6 so quiet", {7'd0, oe_seen}, 8'h00);
    rdsr(st);
    chk("R6 nothing taken", st, 8'h00);

    // R7 status write
    cmd1(8'h06);
    fbegin(); send(8'h01); send(8'hFC); fend();
    wait_ready();
    rdsr(st);
    chk("R7 status stored", st, 8'hFC);
    cmd1(8'h06);
    fbegin(); send(8'h01); send(8'h30); bits(8'h00, 1, first); fend();
    rdsr(st);
    chk("R7 17-clock frame", st, 8'hFE);
    fbegin(); send(8'h01); send(8'h30); bits(8'h00, 7, first); fend();
    rdsr(st);
    chk("R7 15-clock frame", st, 8'hFE);
    cmd1(8'h04);

    // R10 mode (1,1)
    mode11 = 1'b1;
    sck = 1'b1;
    ticks(4*HALF);
    cmd1(8'h06);
    wrbuf[0] = 8'h3C;
    write_page(8'h90, 1);
    wait_ready();
    read_seq(8'h90, 1);
    chk("R10 mode11 data", rdbuf[0], 8'h3C);
    rdsr(st);
    chk("R10 mode11 status", st, 8'hFC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule